// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers a bank of level-sensitive interrupt sources and presents them to a primary interrupt controller in two ways. Each source is either folded into one shared cascade request, which the primary controller sees on a single fixed input, or forwarded on its own line past the cascade, straight to the primary input with the same index. A per-source routing mask picks the path. A routed source never reaches the cascade request, so one event is never signalled on both paths.

Software enables sources through set-only and clear-only write ports, so it never has to read, modify and write an enable word. It reads the sampled input levels, the pending cascade status and a lowest-index-first service pointer that tells the handler which source to service next. The lowest sources are wired to the cascade path for good: their routing bits do not exist and read as zero. Vector generation and priority arbitration belong to the primary controller and are not in this block.

Top module: `sic_cascade`

## Requirements
- R1: After reset every enable bit and every routing bit is 0, `cascade_irq_o` is 0 and `direct_o` is 0.
- R2: A write to address 0 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Reading address 0 or 1 returns the enable word.
- R3: A write to address 1 clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Writing all ones clears every enable bit.
- R4: Reading address 3 returns the source levels registered on the previous clock edge. Writes to addresses 3, 4 and 5 change neither the enables nor the routing mask.
- R5: Reading address 4 returns the pending cascade status, `raw & enable & ~route`.
- R6: `cascade_irq_o` is 1 exactly when the pending cascade status is nonzero.
- R7: `direct_o[n]` equals `raw[n] & route[n]` and does not depend on the enable bits. A source with its routing bit set never appears in the cascade status.
- R8: Routing bits below index `CASC_ONLY` (default 9) cannot be set. A write to address 2 stores `wr_data` with those bits forced to 0, and reading address 2 returns the stored mask.
- R9: Reading address 5 returns bit N-1 = 1 and the index of the lowest pending cascade source in bits 4:0. When no source is pending it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (combinational read) |
| rd_data | output | 32 | Read data |
| cascade_irq_o | output | 1 | Combined request for the fixed primary input |
| direct_o | output | 32 | Per-source requests routed past the cascade |

## Verification
The bench builds the block with its defaults: 32 sources and a fixed cascade-only range of 9. With these values the typical routing mask, the upper bits 20 and 22 to 31, can be exercised as written. An all-ones routing write shows that the forced-cascade range holds. A pending source in the top bit checks that the service pointer reaches the last index.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_EN_SET = 3'd0,
    A_EN_CLR = 3'd1,
    A_ROUTE  = 3'd2,
    A_RAW    = 3'd3,
    A_PEND   = 3'd4,
    A_NEXT   = 3'd5
  } sic_addr_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N        = 32,
  parameter int CASC_ONLY = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      raw_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      route_q
);
  logic do_set, do_clr, do_route;
  assign do_set   = wr_en && (wr_addr == A_EN_SET);
  assign do_clr   = wr_en && (wr_addr == A_EN_CLR);
  assign do_route = wr_en && (wr_addr == A_ROUTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= src_i;
      if (do_set)      en_q <= en_q | wr_data;
      else if (do_clr) en_q <= en_q & ~wr_data;
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_route
    if (b < CASC_ONLY) begin : g_fixed
      assign route_q[b] = 1'b0;
    end else begin : g_bit
      logic r_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        r_q <= 1'b0;
        else if (do_route) r_q <= wr_data[b];
      end
      assign route_q[b] = r_q;
    end
  end

  p_raw_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> raw_q == $past(src_i));
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> (en_q & $past(wr_data)) == $past(wr_data));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (en_q & $past(wr_data)) == '0);
  p_ro_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= A_RAW) |=> $stable(en_q) && $stable(route_q));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N    = 32,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    raw_q,
  input  logic [N-1:0]    en_q,
  input  logic [N-1:0]    route_q,
  output logic [N-1:0]    pend,
  output logic [N-1:0]    direct,
  output logic            irq,
  output logic            next_vld,
  output logic [IDXW-1:0] next_idx
);
  function automatic logic [IDXW:0] lowest_set(input logic [N-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDXW'(i)};
    return r;
  endfunction

  logic [IDXW:0] first;
  assign pend   = raw_q & en_q & ~route_q;
  assign direct = raw_q & route_q;
  assign irq    = |pend;
  assign first  = lowest_set(pend);
  assign next_vld = first[IDXW];
  assign next_idx = first[IDXW-1:0];
endmodule

// File: rtl/sic_cascade.sv
module sic_cascade
  import sic_pkg::*;
#(
  parameter int N         = 32,
  parameter int CASC_ONLY = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  output logic              cascade_irq_o,
  output logic [N-1:0]      direct_o
);
  localparam int IDXW = $clog2(N);

  logic [N-1:0]    raw_q, en_q, route_q, pend;
  logic            next_vld;
  logic [IDXW-1:0] next_idx;

  sic_regs #(.N(N), .CASC_ONLY(CASC_ONLY)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .raw_q(raw_q), .en_q(en_q), .route_q(route_q)
  );

  sic_route #(.N(N), .IDXW(IDXW)) u_route (
    .raw_q(raw_q), .en_q(en_q), .route_q(route_q),
    .pend(pend), .direct(direct_o), .irq(cascade_irq_o),
    .next_vld(next_vld), .next_idx(next_idx)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN_SET, A_EN_CLR: rd_data = en_q;
      A_ROUTE:            rd_data = route_q;
      A_RAW:              rd_data = raw_q;
      A_PEND:             rd_data = pend;
      A_NEXT: begin
        rd_data[N-1]      = next_vld;
        rd_data[IDXW-1:0] = next_idx;
      end
      default:            rd_data = '0;
    endcase
  end

  p_no_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_o & pend) == '0);
  p_fixed_cascade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    direct_o[CASC_ONLY-1:0] == '0);
  p_next_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    next_vld |-> pend[next_idx] && cascade_irq_o);
  p_irq_has_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_irq_o |-> next_vld);
endmodule

// File: tb/sim_sic_cascade.sv
module sim_sic_cascade;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam logic [N-1:0] FIXED = 32'h0000_01FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_i = '0, wr_data = '0, rd_data, direct_o;
  logic wr_en = 1'b0, cascade_irq_o;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  int n_run = 0, n_fail = 0;
  logic [N-1:0] m_en = '0, m_route = '0, m_raw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sic_cascade u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cascade_irq_o(cascade_irq_o), .direct_o(direct_o));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_next(input logic [N-1:0] p);
    for (int i = 0; i < N; i++)
      if (p[i]) return 32'h8000_0000 | 32'(i);
    return '0;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 3'd0) m_en = m_en | d;
    if (a == 3'd1) m_en = m_en & ~d;
    if (a == 3'd2) m_route = d & ~FIXED;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [N-1:0] s);
    @(negedge clk);
    src_i = s; m_raw = s;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic check_outputs(input string req);
    logic [N-1:0] p, d;
    p = m_raw & m_en & ~m_route;
    rd(3'd4, d); chk({req, " pend"}, d, p);
    chk({req, " irq"}, {31'b0, cascade_irq_o}, {31'b0, p != '0});
    chk({req, " direct"}, direct_o, m_raw & m_route);
    rd(3'd5, d); chk({req, " next"}, d, exp_next(p));
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    rd(3'd0, d); chk("R1 enables", d, '0);
    rd(3'd2, d); chk("R1 route", d, '0);
    chk("R1 irq", {31'b0, cascade_irq_o}, '0);
    chk("R1 direct", direct_o, '0);
  endtask

  task automatic t_set;
    logic [N-1:0] d;
    wr(3'd0, 32'h0000_0011); wr(3'd0, 32'h0000_0100);
    rd(3'd0, d); chk("R2 set accumulates", d, 32'h0000_0111);
  endtask

  task automatic t_clear;
    logic [N-1:0] d;
    wr(3'd1, 32'h0000_0010);
    rd(3'd1, d); chk("R3 clear one", d, 32'h0000_0101);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R3 clear all", d, '0);
  endtask

  task automatic t_raw;
    logic [N-1:0] d;
    drive(32'hA5A5_0003);
    rd(3'd3, d); chk("R4 raw sampled", d, 32'hA5A5_0003);
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R4 ro enables", d, '0);
    rd(3'd2, d); chk("R4 ro route", d, '0);
    rd(3'd3, d); chk("R4 raw kept", d, 32'hA5A5_0003);
  endtask

  task automatic t_masked;
    wr(3'd0, 32'h0000_F00F); wr(3'd2, 32'hFFD0_0000);
    drive(32'hFFFF_FFFF); check_outputs("R5 R6 R7 typical mask");
    wr(3'd1, 32'hFFFF_FFFF);
    drive(32'h0010_0000); check_outputs("R7 direct without enable");
    wr(3'd0, 32'hFFFF_FFFF);
    check_outputs("R7 routed bit excluded");
    drive(32'h0000_0000); check_outputs("R6 idle");
  endtask

  task automatic t_fixed;
    logic [N-1:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R8 route readback", d, 32'hFFFF_FE00);
    drive(32'h0000_01FF); check_outputs("R8 low forced cascade");
  endtask

  task automatic t_next;
    wr(3'd2, 32'h0000_0000);
    drive(32'h0000_0A00); check_outputs("R9 lowest of two");
    drive(32'h8000_0000); check_outputs("R9 top index");
    drive(32'h0000_0001); check_outputs("R9 index zero");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_set; t_clear; t_raw; t_masked; t_fixed; t_next;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule